// File: doc/BRIEF.md
# Symmetric FIR Filter with Single Merged Product Matrix

This block is an even-order, linear-phase FIR filter in direct form. It keeps a short history of signed input samples. It multiplies each sample by a fixed signed coefficient and sums all the products. It returns only the upper bits of that sum, rounded so that the result is always within one output unit of the exact value.

The products are not built one tap at a time. Mirrored taps are first added together, because their coefficients are equal. Each coefficient is rewritten at elaboration as a short list of signed powers of two. Every shifted copy of a pre-added sample then becomes one row of a single bit matrix. Sign extension is replaced by inverting each row's top bit. The constants that this leaves, together with the rounding offset, are folded into one extra row. Columns well below the output weight are left out of the data rows. The matrix is reduced to two rows by 3:2 compressors, and one carry-propagate adder produces the sum.

The host supplies a sample together with a valid strobe. One clock later, the filtered value appears at the output together with its own valid strobe.

Top module: `fir_merged_matrix`

## Requirements
- R1: Reset clears the output strobe, the output value and the sample history. After reset, filtering starts as if every earlier sample were zero.
- R2: The output strobe is high in exactly those cycles that follow a cycle in which the input strobe was high.
- R3: The sample history advances only on a cycle with the input strobe high. Idle cycles between samples do not change later results.
- R4: Each output, read as a signed OUT_W-bit value v, satisfies |v·2^K − y| < 2^K. Here y is the exact sum of a_i·x[n−i] over i = 0..ORDER, and K = DATA_W + COEF_W + ceil(log2(ORDER+1)) − OUT_W. With the defaults, K = 13.
- R5: The coefficient set is symmetric: a_i = a_(ORDER−i). The parameter COEF_HALF lists a_0 up to the centre tap a_(ORDER/2). An impulse therefore gives equal outputs at delays i and ORDER−i.
- R6: The output value keeps its last result during idle cycles.
- R7: Sustained full-scale inputs, both all most-positive and all most-negative samples, still meet the R4 bound without wrap-around.
- R8: Each coefficient is realised as a sum of signed power-of-two terms. The recoding used is whichever of canonical signed digit and radix-4 Booth has fewer nonzero digits; on a tie, Booth is used. Negative coefficients and coefficients with runs of ones are reproduced to the R4 bound. This is observed as the response to impulses of either sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Sample strobe |
| inData | input | DATA_W | Signed input sample |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| outData | output | OUT_W | Signed, faithfully rounded upper bits of the filter sum |

## Verification
Single impulses of both signs, each followed by zeros, trace out the coefficients one at a time. Comparing mirrored delays separates a correct symmetric fold from a wrong tap pairing. Long full-scale runs of either sign drive every matrix column and the sign-bias row toward their limits, which exposes a wrong bias constant or a wrong output width. Random samples with random idle gaps mix all taps together and exercise history handling, the output strobe and the hold behaviour.

// File: rtl/fir_mm_pkg.sv
package fir_mm_pkg;

  typedef struct packed {
    logic shiftEn;
    logic captureEn;
  } firStrobe_t;

  // Returns (shift*2 + negative) for the idx-th nonzero term of the cheaper
  // recoding of coefficient c (width cw), or -1 when there is no such term.
  function automatic int termCode(int c, int cw, int idx);
    int csdT[64];
    int bthT[64];
    int nc;
    int nb;
    int x;
    int d;
    int mag;
    int b0;
    int b1;
    int b2;
    nc = 0;
    nb = 0;
    x = c;
    for (int i = 0; i <= cw + 1; i++) begin
      if ((x & 1) != 0) begin
        d = ((x & 3) == 1) ? 1 : -1;
        csdT[nc] = i * 2 + ((d < 0) ? 1 : 0);
        nc++;
        x = x - d;
      end
      x = x >>> 1;
    end
    for (int i = 0; i < cw; i += 2) begin
      b0 = (i == 0) ? 0 : ((c >>> (i - 1)) & 1);
      b1 = (c >>> i) & 1;
      b2 = (c >>> (i + 1)) & 1;
      d = b1 + b0 - 2 * b2;
      if (d != 0) begin
        mag = (d < 0) ? -d : d;
        bthT[nb] = (i + ((mag == 2) ? 1 : 0)) * 2 + ((d < 0) ? 1 : 0);
        nb++;
      end
    end
    if (nb <= nc) return (idx < nb) ? bthT[idx] : -1;
    return (idx < nc) ? csdT[idx] : -1;
  endfunction

endpackage

// File: rtl/fir_mm_ctrl.sv
module fir_mm_ctrl
  import fir_mm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output firStrobe_t strobe,
  output logic       outValid
);

  always_comb begin
    strobe.shiftEn   = inValid;
    strobe.captureEn = inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/fir_mm_datapath.sv
module fir_mm_datapath
  import fir_mm_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int COEF_W = 10,
  parameter int OUT_W  = 12,
  parameter int ORDER  = 4,
  parameter int COEF_HALF [ORDER/2+1] = '{-23, 87, 301}
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  firStrobe_t               strobe,
  input  logic signed [DATA_W-1:0] inData,
  output logic        [OUT_W-1:0]  outData
);

  localparam int HALF   = ORDER / 2 + 1;
  localparam int PW     = DATA_W + 1;
  localparam int FW     = DATA_W + COEF_W + $clog2(ORDER + 1);
  localparam int K      = FW - OUT_W;
  localparam int NDIG   = (COEF_W + 1) / 2;
  localparam int NDATA  = HALF * NDIG;
  localparam int NROW   = NDATA + 1;
  localparam int GUARD  = $clog2(NDATA) + 1;
  localparam int CUT    = (K > GUARD) ? K - GUARD : 0;
  localparam logic [FW-1:0] ONE  = FW'(1);
  localparam logic [FW-1:0] KEEP = ~((ONE << CUT) - ONE);
  localparam logic [FW-1:0] HALF_ULP = ONE << (K - 1);

  logic signed [DATA_W-1:0] dly  [ORDER];
  logic signed [DATA_W-1:0] taps [ORDER+1];
  logic signed [PW-1:0]     pre  [HALF];
  logic [FW-1:0]            mat  [NROW];
  logic [FW-1:0]            tBias [NDATA];
  logic [FW-1:0]            cur  [NROW];
  logic [FW-1:0]            nxt  [NROW];
  logic [FW-1:0]            sumA, sumB, total, matTotal;

  // Delay line: taps[0] is the sample being accepted this cycle.
  assign taps[0] = inData;
  for (genvar i = 0; i < ORDER; i++) begin : g_tap
    assign taps[i+1] = dly[i];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               dly[i] <= '0;
      else if (strobe.shiftEn) dly[i] <= taps[i];
    end
  end

  // Fold mirrored taps; centre tap stands alone.
  for (genvar j = 0; j < HALF; j++) begin : g_pre
    if (j < ORDER / 2) begin : g_pair
      assign pre[j] = PW'(taps[j]) + PW'(taps[ORDER-j]);
    end else begin : g_mid
      assign pre[j] = PW'(taps[j]);
    end
  end

  // One matrix row per nonzero recoded digit.
  for (genvar j = 0; j < HALF; j++) begin : g_coef
    for (genvar t = 0; t < NDIG; t++) begin : g_term
      localparam int CODE = termCode(COEF_HALF[j], COEF_W, t);
      if (CODE >= 0) begin : g_on
        localparam int SH = CODE / 2;
        localparam bit NEG = (CODE % 2) != 0;
        logic [PW-1:0] body;
        assign body = NEG ? {pre[j][PW-1], ~pre[j][PW-2:0]}
                          : {~pre[j][PW-1], pre[j][PW-2:0]};
        assign mat[j*NDIG+t]   = ({{(FW-PW){1'b0}}, body} << SH) & KEEP;
        assign tBias[j*NDIG+t] = (NEG ? (ONE << SH) : '0) - (ONE << (PW - 1 + SH));
      end else begin : g_off
        assign mat[j*NDIG+t]   = '0;
        assign tBias[j*NDIG+t] = '0;
      end
    end
  end

  // Bias row: folded sign constants plus the rounding half-unit.
  always_comb begin
    mat[NROW-1] = HALF_ULP;
    for (int r = 0; r < NDATA; r++) mat[NROW-1] = mat[NROW-1] + tBias[r];
  end

  // Carry-save reduction to two rows.
  always_comb begin
    int n;
    int m;
    cur = mat;
    nxt = cur;
    n = NROW;
    for (int lv = 0; lv < NROW; lv++) begin
      if (n > 2) begin
        nxt = '{default: '0};
        m = 0;
        for (int g = 0; g < NROW; g += 3) begin
          if (g + 2 < n) begin
            nxt[m]   = cur[g] ^ cur[g+1] ^ cur[g+2];
            nxt[m+1] = ((cur[g] & cur[g+1]) | (cur[g] & cur[g+2]) |
                        (cur[g+1] & cur[g+2])) << 1;
            m = m + 2;
          end else if (g < n) begin
            nxt[m] = cur[g];
            m = m + 1;
            if (g + 1 < n) begin
              nxt[m] = cur[g+1];
              m = m + 1;
            end
          end
        end
        cur = nxt;
        n = m;
      end
    end
    sumA = cur[0];
    sumB = cur[1];
  end

  assign total = sumA + sumB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 outData <= '0;
    else if (strobe.captureEn) outData <= total[FW-1:K];
  end

  // Reference sum of the uncompressed matrix, used only by the checks below.
  always_comb begin
    matTotal = '0;
    for (int r = 0; r < NROW; r++) matTotal = matTotal + mat[r];
  end

  p_csa_sum_r4: assert property (@(posedge clk) disable iff (!rstN)
    total == matTotal);
  p_shift_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> dly[0] == $past(inData));
  p_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn |=> $stable(dly[ORDER-1]));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.captureEn |=> $stable(outData));

endmodule

// File: rtl/fir_merged_matrix.sv
module fir_merged_matrix
  import fir_mm_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int COEF_W = 10,
  parameter int OUT_W  = 12,
  parameter int ORDER  = 4,
  parameter int COEF_HALF [ORDER/2+1] = '{-23, 87, 301}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [OUT_W-1:0]  outData
);

  firStrobe_t strobe;

  fir_mm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  fir_mm_datapath #(
    .DATA_W    (DATA_W),
    .COEF_W    (COEF_W),
    .OUT_W     (OUT_W),
    .ORDER     (ORDER),
    .COEF_HALF (COEF_HALF)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inData  ($signed(inData)),
    .outData (outData)
  );

endmodule

// File: tb/fir_merged_matrix_tb.sv
module fir_merged_matrix_tb;

  localparam int DATA_W = 12;
  localparam int COEF_W = 10;
  localparam int OUT_W  = 12;
  localparam int ORDER  = 4;
  localparam int HALFC [ORDER/2+1] = '{-23, 87, 301};
  localparam int K = DATA_W + COEF_W + $clog2(ORDER + 1) - OUT_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic outValid;
  logic [OUT_W-1:0] outData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  longint hist[$];
  longint lastOut = 0;
  longint imp[ORDER+1];

  always #10 clk = ~clk;

  fir_merged_matrix #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .OUT_W(OUT_W),
    .ORDER(ORDER), .COEF_HALF(HALFC)
  ) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  function automatic longint coefAt(int i);
    return longint'(HALFC[(i <= ORDER / 2) ? i : ORDER - i]);
  endfunction

  function automatic longint exactSum();
    longint s = 0;
    for (int i = 0; i < hist.size(); i++) s += coefAt(i) * hist[i];
    return s;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle at negedge, check outputs at the following negedge.
  task automatic step(bit v, longint d, string req);
    longint ex;
    longint hw;
    longint diff;
    inValid = v;
    inData = DATA_W'(d);
    if (v) begin
      hist.push_front(d);
      if (hist.size() > ORDER + 1) void'(hist.pop_back());
    end
    ex = exactSum();
    @(negedge clk);
    check(outValid == v, "R2 strobe", longint'(outValid), longint'(v));
    hw = longint'($signed(outData));
    if (v) begin
      diff = hw * (longint'(1) << K) - ex;
      if (diff < 0) diff = -diff;
      check(diff < (longint'(1) << K), req, hw * (longint'(1) << K), ex);
      lastOut = hw;
    end else begin
      check(hw == lastOut, "R6 hold", hw, lastOut);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 strobe", longint'(outValid), 0);
    check(outData == '0, "R1 data", longint'(outData), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: first sample after reset sees zero history
    step(1, 1000, "R1 history");
    step(0, 0, "R6");
    step(0, 0, "R6");

    // R5 / R8: positive impulse response
    for (int i = 0; i < ORDER; i++) step(1, 0, "R4 flush");
    step(1, 2047, "R8 impulse+");
    imp[0] = lastOut;
    for (int i = 1; i <= ORDER; i++) begin
      step(1, 0, "R8 impulse+");
      imp[i] = lastOut;
    end
    for (int i = 0; i < ORDER / 2; i++)
      check(imp[i] == imp[ORDER-i], "R5 symmetry", imp[i], imp[ORDER-i]);

    // R8: negative impulse
    step(1, -2048, "R8 impulse-");
    for (int i = 1; i <= ORDER; i++) step(1, 0, "R8 impulse-");

    // R7: full-scale runs
    for (int i = 0; i < 8; i++) step(1, 2047, "R7 max");
    for (int i = 0; i < 8; i++) step(1, -2048, "R7 min");
    for (int i = 0; i < 8; i++) step(1, (i % 2 == 0) ? 2047 : -2048, "R7 alt");

    // R3 / R4: random samples with random idle gaps
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 3) == 0) step(0, 0, "R3 gap");
      else step(1, longint'($signed(DATA_W'($urandom))), "R4 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule